// File: doc/BRIEF.md
# Conditional Branch and Link Unit

This block produces the program counter of a simple 32-bit processor, one value per clock. Every cycle it receives a decoded control-flow request made of an operation code, a 4-bit condition and a target address, along with the four status flags left by earlier arithmetic. It tests the condition against the flags and loads the next PC. That next PC is the sequential address, the supplied target, or the saved return address.

A branch-with-link that is taken moves to the target. On the same clock edge it stores the sequential address into a link register. A return that is taken copies the link register into the PC. A request whose condition fails falls through to the next sequential instruction. Fetch, decode, target arithmetic and the ALU are outside this block.

Top module: `nxtpc_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o`, `lr_o` and `redirect_o` become 0 at that edge (synchronous, active-high).
- R2: With `op_i` = 2'b00 (sequential), the next edge loads `pc_o` with `pc_o` + 4 and clears `redirect_o`. Condition, flags and target are ignored.
- R3: With `op_i` = 2'b01 (branch) and the condition true, the next edge loads `pc_o` with `target_i` and sets `redirect_o`. With the condition false, `pc_o` advances by 4 and `redirect_o` is 0.
- R4: With `op_i` = 2'b10 (branch-with-link) and the condition true, the same edge loads `pc_o` with `target_i` and `lr_o` with the old `pc_o` + 4.
- R5: `lr_o` changes only on a taken branch-with-link or on reset. A not-taken branch-with-link leaves it unchanged.
- R6: With `op_i` = 2'b11 (return) and the condition true, the next edge loads `pc_o` with `lr_o` and leaves `lr_o` unchanged. With the condition false, `pc_o` advances by 4.
- R7: `flags_i` packs the flags as N = bit 3, Z = bit 2, C = bit 1, V = bit 0. Each `cond_i` code is true under the flag test listed here:

  | Code | Test |
  |------|------|
  | 0 | Z |
  | 1 | !Z |
  | 2 | C |
  | 3 | !C |
  | 4 | N |
  | 5 | !N |
  | 6 | V |
  | 7 | !V |
  | 8 | C & !Z |
  | 9 | !C \| Z |
  | 10 | N == V |
  | 11 | N != V |
  | 12 | !Z & (N == V) |
  | 13 | Z \| (N != V) |

- R8: Condition code 14 is always true, whatever the flags. Code 15 is never true, so a request with code 15 always falls through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Control-flow request: 00 sequential, 01 branch, 10 branch-with-link, 11 return |
| cond_i | input | 4 | Condition code (R7, R8) |
| flags_i | input | 4 | Status flags {N, Z, C, V} |
| target_i | input | ADDR_W | Branch target address |
| pc_o | output | ADDR_W | Registered program counter |
| lr_o | output | ADDR_W | Registered link register |
| redirect_o | output | 1 | High for the cycle after an edge that transferred control |

## Verification
Every result of this block is due exactly one rising edge after its request:
- the new PC,
- the link write,
- the redirect flag.

The bench drives each request on a falling edge and compares all three outputs at the next falling edge, half a cycle after the edge that registered them. The expected values come from a bench model that advances once per cycle.

The sweep walks every operation against every condition code and all sixteen flag patterns. The return requests come after the link sweep, so they read a known link value. A reset is also applied mid-run, after the link register holds a nonzero value.

// File: rtl/nxtpc_pkg.sv
package nxtpc_pkg;

  typedef enum logic [1:0] {
    OP_SEQ = 2'b00,
    OP_BR  = 2'b01,
    OP_BRL = 2'b10,
    OP_RET = 2'b11
  } op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  localparam int COND_W    = 4;
  localparam int FLAG_W    = 4;
  localparam int N_PAIRS   = 8;
  localparam logic [COND_W-1:0] COND_ALWAYS = 4'd14;
  localparam logic [COND_W-1:0] COND_NEVER  = 4'd15;

endpackage

// File: rtl/nxtpc_cond_eval.sv
module nxtpc_cond_eval
  import nxtpc_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              pass_o
);

  logic n_f, z_f, c_f, v_f;
  logic [N_PAIRS-1:0]   base;
  logic [2*N_PAIRS-1:0] pass_vec;

  assign n_f = flags_i[FLAG_N];
  assign z_f = flags_i[FLAG_Z];
  assign c_f = flags_i[FLAG_C];
  assign v_f = flags_i[FLAG_V];

  // Even codes test a predicate, odd codes its inverse.
  assign base[0] = z_f;
  assign base[1] = c_f;
  assign base[2] = n_f;
  assign base[3] = v_f;
  assign base[4] = c_f & ~z_f;
  assign base[5] = ~(n_f ^ v_f);
  assign base[6] = ~z_f & ~(n_f ^ v_f);
  assign base[7] = 1'b1;

  for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
    assign pass_vec[2*g]   = base[g];
    assign pass_vec[2*g+1] = ~base[g];
  end

  assign pass_o = pass_vec[cond_i];

endmodule

// File: rtl/nxtpc_select.sv
module nxtpc_select
  import nxtpc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PC_STEP = 4
) (
  input  logic [1:0]        op_i,
  input  logic              pass_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] lr_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic [ADDR_W-1:0] seq_pc_o,
  output logic              lr_we_o,
  output logic              redirect_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  op_e op;
  assign op       = op_e'(op_i);
  assign seq_pc_o = pc_i + STEP;

  always_comb begin
    next_pc_o  = seq_pc_o;
    lr_we_o    = 1'b0;
    redirect_o = 1'b0;
    if (pass_i) begin
      unique case (op)
        OP_SEQ: ;
        OP_BR: begin
          next_pc_o  = target_i;
          redirect_o = 1'b1;
        end
        OP_BRL: begin
          next_pc_o  = target_i;
          lr_we_o    = 1'b1;
          redirect_o = 1'b1;
        end
        OP_RET: begin
          next_pc_o  = lr_i;
          redirect_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nxtpc_ctrl.sv
module nxtpc_ctrl
  import nxtpc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        flags_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] lr_o,
  output logic              redirect_o
);

  logic              pass;
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] seq_pc;
  logic              lr_we;
  logic              redirect_d;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] lr_q;
  logic              redirect_q;

  nxtpc_cond_eval u_cond (
    .flags_i (flags_i),
    .cond_i  (cond_i),
    .pass_o  (pass)
  );

  nxtpc_select #(
    .ADDR_W  (ADDR_W),
    .PC_STEP (PC_STEP)
  ) u_sel (
    .op_i       (op_i),
    .pass_i     (pass),
    .pc_i       (pc_q),
    .lr_i       (lr_q),
    .target_i   (target_i),
    .next_pc_o  (next_pc),
    .seq_pc_o   (seq_pc),
    .lr_we_o    (lr_we),
    .redirect_o (redirect_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      lr_q       <= '0;
      redirect_q <= 1'b0;
    end else begin
      pc_q       <= next_pc;
      redirect_q <= redirect_d;
      if (lr_we) lr_q <= seq_pc;
    end
  end

  assign pc_o       = pc_q;
  assign lr_o       = lr_q;
  assign redirect_o = redirect_q;

endmodule

// File: rtl/nxtpc_ctrl_chk.sv
module nxtpc_ctrl_chk
  import nxtpc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PC_STEP = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        op_i,
  input logic [3:0]        cond_i,
  input logic [ADDR_W-1:0] target_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] lr_o,
  input logic              redirect_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && lr_o == '0 && !redirect_o));

  p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SEQ) |=> (pc_o == $past(pc_o) + STEP && !redirect_o));

  p_branch_dest_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_BR || op_i == OP_BRL) |=>
      (redirect_o ? (pc_o == $past(target_i)) : (pc_o == $past(pc_o) + STEP)));

  p_link_save_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_BRL) |=>
      (redirect_o ? (lr_o == $past(pc_o) + STEP) : $stable(lr_o)));

  p_link_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i != OP_BRL) |=> $stable(lr_o));

  p_return_dest_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RET) |=>
      (redirect_o ? (pc_o == $past(lr_o)) : (pc_o == $past(pc_o) + STEP)));

  p_always_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i != OP_SEQ && cond_i == COND_ALWAYS) |=> redirect_o);

  p_never_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (cond_i == COND_NEVER) |=> !redirect_o);

endmodule

bind nxtpc_ctrl nxtpc_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .PC_STEP (PC_STEP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_i       (op_i),
  .cond_i     (cond_i),
  .target_i   (target_i),
  .pc_o       (pc_o),
  .lr_o       (lr_o),
  .redirect_o (redirect_o)
);

// File: tb/nxtpc_ctrl_tb.sv
`timescale 1ns/1ps
module nxtpc_ctrl_tb;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    op_i = 2'b00;
  logic [3:0]    cond_i = 4'd0;
  logic [3:0]    flags_i = 4'd0;
  logic [AW-1:0] target_i = '0;
  logic [AW-1:0] pc_o;
  logic [AW-1:0] lr_o;
  logic          redirect_o;

  int n_checks = 0;
  int n_fails  = 0;

  logic [AW-1:0] m_pc = '0;
  logic [AW-1:0] m_lr = '0;
  logic          m_redir = 1'b0;

  always #5 clk = ~clk;

  nxtpc_ctrl #(.ADDR_W(AW), .PC_STEP(4)) u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .cond_i(cond_i), .flags_i(flags_i),
    .target_i(target_i), .pc_o(pc_o), .lr_o(lr_o), .redirect_o(redirect_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Condition truth from the table in R7/R8; flags {N,Z,C,V}
  function automatic logic cond_true(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Called at a falling edge: drive one request, then check at the next falling edge
  task automatic step(input logic [1:0] op, input logic [3:0] c,
                      input logic [3:0] f, input logic [AW-1:0] tgt);
    logic          take;
    logic [AW-1:0] nxt;
    string         rp, rl, rr;
    op_i = op; cond_i = c; flags_i = f; target_i = tgt;
    take = (op != 2'b00) && cond_true(c, f);
    nxt  = m_pc + 32'd4;
    rl   = "R5";
    case (op)
      2'b00: rp = "R2";
      2'b01: rp = "R3";
      2'b10: rp = "R4";
      default: rp = "R6";
    endcase
    if (take) begin
      if (op == 2'b11) nxt = m_lr;
      else nxt = tgt;
      if (op == 2'b10) begin
        m_lr = m_pc + 32'd4;
        rl   = "R4";
      end
    end
    m_pc    = nxt;
    m_redir = take;
    rr = (c >= 4'd14) ? "R8" : ((op == 2'b00) ? "R2" : "R7");
    @(negedge clk);
    chk(rp, "pc", pc_o, m_pc);
    chk(rl, "lr", lr_o, m_lr);
    chk(rr, "redirect", {31'd0, redirect_o}, {31'd0, m_redir});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "pc", pc_o, '0);
    chk("R1", "lr", lr_o, '0);
    chk("R1", "redirect", {31'd0, redirect_o}, 32'd0);
    rst = 1'b0;
    m_pc = '0; m_lr = '0;
    // Sweep: operation x condition x flags (R2..R8)
    for (int op = 0; op < 4; op++)
      for (int c = 0; c < 16; c++)
        for (int f = 0; f < 16; f++)
          step(op[1:0], c[3:0], f[3:0],
               32'h4000_0000 + (op << 16) + (c << 8) + (f << 4));
    // R5: a failing link request after a capture must keep the saved value
    step(2'b10, 4'd14, 4'd0, 32'h0000_8000);
    step(2'b10, 4'd0, 4'b0000, 32'h0000_9000);
    chk("R5", "lr after not-taken link", lr_o, 32'h0000_8000 - 32'h0000_8000 + m_lr);
    // R6: return to the captured address
    step(2'b11, 4'd14, 4'd0, 32'hdead_beec);
    // R1: mid-run reset with nonzero link register
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "pc mid-run", pc_o, '0);
    chk("R1", "lr mid-run", lr_o, '0);
    chk("R1", "redirect mid-run", {31'd0, redirect_o}, 32'd0);
    rst = 1'b0;
    m_pc = '0; m_lr = '0;
    step(2'b00, 4'd14, 4'd0, 32'h1234_5678);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule